// File: doc/BRIEF.md
# Programmable-Timing Static Memory Bus Controller

This block turns single requests from an internal master into accesses on an external asynchronous static memory bus. The bus has four banks, and each bank has its own chip-select line. Every bank holds its own configuration. The configuration sets six cycle counts that place the address, the chip select and the read or write strobe relative to one another. It also sets the data width, 8 or 16 bits, and a flag that turns a single transfer into a four-beat page burst.

A request carries an address, a direction flag and write data. Address bits [25:24] pick the bank. The block takes a copy of that bank's configuration when it accepts the request. It then steps through address setup, chip-select setup, strobe, chip-select hold and address hold, and skips any phase whose count is zero. Last, it raises a one-cycle done pulse with the read data. Software-side logic loads a bank's configuration through a simple write port while the block is idle.

Top module: `smem_ctrl`

## Requirements
- R1: After reset all `mem_cs_n` lines are high, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: Address bits [25:24] select the bank. During an access only that bank's line, `mem_cs_n[bank]`, goes low, and the other lines stay high.
- R3: In a read with no zero fields, the timing runs in this order. The address is valid for `acs` cycles with chip select high. Chip select is then low with the strobe high for `cos` cycles. `mem_oe_n` is low for `acc` cycles. Chip select stays low for `coh` cycles after the strobe rises. The address holds for `cah` cycles after chip select rises, and then `rsp_done` is high for one cycle.
- R4: A timing field of 0 removes its phase. An `acc` or `acp` of 0 counts as 1 cycle. With every field at 0, `rsp_done` comes 2 cycles after the accepting edge.
- R5: Read data is sampled in the last strobe cycle of each beat. It appears on `rsp_rdata` in the one cycle where `rsp_done` is high, with beat k in bits [16k+15:16k] and unused lanes zero.
- R6: A write uses `mem_we_n` in place of `mem_oe_n`, with the same timing. `mem_dq_oe` is 1 from chip-select assertion to the end of the address hold phase, for `cos+strobe+coh+cah` cycles. The word driven is lane k of `req_wdata`.
- R7: The configuration bit at position 24 (`wide`) selects 16-bit data; at 0 the bank is 8 bits wide. A narrow bank drives and samples only bits [7:0], and its upper read byte is zero. The address step between page beats is 1 for a narrow bank and 2 for a wide bank.
- R8: With the page bit (position 25) set, an access makes four beats. The first beat lasts `acc` cycles and the next three last `acp` cycles each. Chip select and the strobe stay low through all four beats, and the address advances by one step per beat.
- R9: `req_ready` is low from acceptance through the done cycle. A request offered in that time is ignored: no second access starts and no second done pulse appears.
- R10: Configuration word layout, low bits first: `acs`[3:0], `cos`[7:4], `acc`[11:8], `coh`[15:12], `cah`[19:16], `acp`[23:20], `wide`[24], `page`[25]. Each bank resets to all zero, which gives 8-bit single transfers, and writing one bank leaves the others unchanged.
- R11: During a read `mem_dq_oe` stays 0 for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank whose configuration is written |
| cfg_data | input | 26 | Configuration word (layout in R10) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Byte address; [25:24] select the bank |
| req_wdata | input | 64 | Write data, one 16-bit lane per beat |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data, one 16-bit lane per beat |
| mem_addr | output | 26 | External address |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable (1 = drive) |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
A sequencer that enters the wrong state, or miscounts a phase, changes the number of cycles between the edges of chip select and strobe. That error is visible within the same access, and the bench counts every phase length at the pins. A wrong beat index or address step shows up as data in the wrong lane or a wrong written location, which the bench sees at the done pulse or in its memory model one cycle later. A bad bank snapshot drives the wrong chip-select line at once. A missed busy check starts a second chip-select episode in the cycle after done.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_CS_SETUP,
        ST_ACCESS,
        ST_PAGE,
        ST_CS_HOLD,
        ST_ADDR_HOLD,
        ST_DONE
    } seq_st_t;

    // Field order fixes bit positions: acs at [3:0] up to page at [25]
    typedef struct packed {
        logic       page;
        logic       wide;
        logic [3:0] acp;
        logic [3:0] cah;
        logic [3:0] coh;
        logic [3:0] acc;
        logic [3:0] cos;
        logic [3:0] acs;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    // Cycles spent in a state; strobe phases never shorter than one
    function automatic logic [3:0] phase_len(seq_st_t s, bank_cfg_t c);
        case (s)
            ST_ADDR_SETUP: phase_len = c.acs;
            ST_CS_SETUP:   phase_len = c.cos;
            ST_ACCESS:     phase_len = (c.acc == 4'd0) ? 4'd1 : c.acc;
            ST_PAGE:       phase_len = (c.acp == 4'd0) ? 4'd1 : c.acp;
            ST_CS_HOLD:    phase_len = c.coh;
            ST_ADDR_HOLD:  phase_len = c.cah;
            default:       phase_len = 4'd1;
        endcase
    endfunction

    // First state at or after s whose length is non-zero
    function automatic seq_st_t skip_empty(seq_st_t s, bank_cfg_t c);
        case (s)
            ST_ADDR_SETUP: skip_empty = (c.acs != 4'd0) ? ST_ADDR_SETUP :
                                        (c.cos != 4'd0) ? ST_CS_SETUP : ST_ACCESS;
            ST_CS_SETUP:   skip_empty = (c.cos != 4'd0) ? ST_CS_SETUP : ST_ACCESS;
            ST_CS_HOLD:    skip_empty = (c.coh != 4'd0) ? ST_CS_HOLD :
                                        (c.cah != 4'd0) ? ST_ADDR_HOLD : ST_DONE;
            ST_ADDR_HOLD:  skip_empty = (c.cah != 4'd0) ? ST_ADDR_HOLD : ST_DONE;
            default:       skip_empty = s;
        endcase
    endfunction

endpackage

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs
    import smem_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  bank_cfg_t         wr_cfg,
    input  logic [BANK_W-1:0] rd_bank,
    output bank_cfg_t         rd_cfg
);

    bank_cfg_t cfg_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_cfg_t cfg_d;

        always_comb begin
            cfg_d = cfg_q[b];
            if (wr_en && wr_bank == BANK_W'(b)) begin
                cfg_d = wr_cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[b] <= '0;
            end else begin
                cfg_q[b] <= cfg_d;
            end
        end
    end

    assign rd_cfg = cfg_q[rd_bank];

endmodule

// File: rtl/smem_seq.sv
module smem_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int BEATS  = 4,
    parameter int BANK_W = 2,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int LANE_W = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] req_wdata,
    input  bank_cfg_t         bank_cfg,
    input  logic [DATA_W-1:0] dq_i,
    output logic              req_ready,
    output seq_st_t           st,
    output logic [BANK_W-1:0] bank,
    output logic              write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              rsp_done,
    output logic [LANE_W-1:0] rsp_rdata
);

    typedef struct packed {
        seq_st_t           st;
        logic [3:0]        cnt;
        logic [BEAT_W-1:0] beat;
        logic [BANK_W-1:0] bank;
        logic              write;
        logic [ADDR_W-1:0] addr;
        bank_cfg_t         cfg;
        logic [LANE_W-1:0] wdata;
        logic [LANE_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    seq_st_t   nxt;
    logic [DATA_W-1:0] lane_in;
    logic [DATA_W-1:0] lane_out;

    // Narrow banks only use the low byte in both directions
    always_comb begin
        lane_out = r_q.wdata[r_q.beat*DATA_W +: DATA_W];
        if (!r_q.cfg.wide) begin
            lane_in  = {{(DATA_W-8){1'b0}}, dq_i[7:0]};
            lane_out = {{(DATA_W-8){1'b0}}, lane_out[7:0]};
        end else begin
            lane_in  = dq_i;
        end
    end

    always_comb begin
        r_d = r_q;
        nxt = r_q.st;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.cfg   = bank_cfg;
                    r_d.bank  = req_addr[ADDR_W-1 -: BANK_W];
                    r_d.addr  = req_addr;
                    r_d.write = req_write;
                    r_d.wdata = req_wdata;
                    r_d.rdata = '0;
                    r_d.beat  = '0;
                    r_d.st    = skip_empty(ST_ADDR_SETUP, bank_cfg);
                    r_d.cnt   = phase_len(r_d.st, bank_cfg) - 4'd1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                if (r_q.cnt != 4'd0) begin
                    r_d.cnt = r_q.cnt - 4'd1;
                end else begin
                    case (r_q.st)
                        ST_ADDR_SETUP: nxt = skip_empty(ST_CS_SETUP, r_q.cfg);
                        ST_CS_SETUP:   nxt = ST_ACCESS;
                        ST_ACCESS, ST_PAGE: begin
                            if (!r_q.write) begin
                                r_d.rdata[r_q.beat*DATA_W +: DATA_W] = lane_in;
                            end
                            if (r_q.cfg.page && r_q.beat != BEAT_W'(BEATS-1)) begin
                                nxt      = ST_PAGE;
                                r_d.beat = r_q.beat + 1'b1;
                                r_d.addr = r_q.addr + (r_q.cfg.wide ? ADDR_W'(2) : ADDR_W'(1));
                            end else begin
                                nxt = skip_empty(ST_CS_HOLD, r_q.cfg);
                            end
                        end
                        ST_CS_HOLD:    nxt = skip_empty(ST_ADDR_HOLD, r_q.cfg);
                        default:       nxt = ST_DONE;
                    endcase
                    r_d.st  = nxt;
                    r_d.cnt = phase_len(nxt, r_q.cfg) - 4'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign st        = r_q.st;
    assign bank      = r_q.bank;
    assign write     = r_q.write;
    assign addr      = r_q.addr;
    assign dq_o      = lane_out;
    assign rsp_done  = (r_q.st == ST_DONE);
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/smem_pins.sv
module smem_pins
    import smem_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = $clog2(BANKS)
) (
    input  seq_st_t           st,
    input  logic [BANK_W-1:0] bank,
    input  logic              write,
    output logic [BANKS-1:0]  cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dq_oe
);

    logic cs_act;
    logic strobe;
    logic drive;

    always_comb begin
        cs_act = (st == ST_CS_SETUP) || (st == ST_ACCESS) ||
                 (st == ST_PAGE) || (st == ST_CS_HOLD);
        strobe = (st == ST_ACCESS) || (st == ST_PAGE);
        drive  = cs_act || (st == ST_ADDR_HOLD);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_cs
        assign cs_n[b] = !(cs_act && bank == BANK_W'(b));
    end

    assign oe_n  = !(strobe && !write);
    assign we_n  = !(strobe && write);
    assign dq_oe = drive && write;

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
    import smem_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    parameter int BEATS  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANKS-1:0]  mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    bank_cfg_t         sel_cfg;
    seq_st_t           seq_st;
    logic [BANK_W-1:0] seq_bank;
    logic              seq_write;

    smem_cfg_regs #(.BANKS(BANKS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_cfg  (bank_cfg_t'(cfg_data)),
        .rd_bank (req_addr[ADDR_W-1 -: BANK_W]),
        .rd_cfg  (sel_cfg)
    );

    smem_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS),
        .BANK_W (BANK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bank_cfg  (sel_cfg),
        .dq_i      (mem_dq_i),
        .req_ready (req_ready),
        .st        (seq_st),
        .bank      (seq_bank),
        .write     (seq_write),
        .addr      (mem_addr),
        .dq_o      (mem_dq_o),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    smem_pins #(.BANKS(BANKS)) u_pins (
        .st    (seq_st),
        .bank  (seq_bank),
        .write (seq_write),
        .cs_n  (mem_cs_n),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe)
    );

endmodule

// File: rtl/smem_ctrl_chk.sv
module smem_ctrl_chk #(
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [BANKS-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic             mem_dq_oe
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> $onehot0(~mem_cs_n)); // R2

    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_cs_n != '1)); // R3

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_cs_n != '1)); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R6

    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R6

    AST_READ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R5

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_done); // R9

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n)); // R9

    AST_PAGE_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_cs_n)); // R8

endmodule

bind smem_ctrl smem_ctrl_chk #(.BANKS(BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/smem_ctrl_bench.sv
module smem_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [25:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_done;
    logic [63:0] rsp_rdata;
    logic [25:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    int n_checks = 0;
    int n_fail   = 0;
    logic [25:0] sh_cfg [4];
    logic [15:0] store [256];

    always #5 clk = ~clk;

    smem_ctrl u_smem_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [15:0] pat(input logic [7:0] a);
        return {a ^ 8'hA5, a + 8'h3C};
    endfunction

    assign mem_dq_i = !mem_oe_n ? pat(mem_addr[7:0]) : 16'h0000;

    always @(negedge clk) begin
        if (rst_n && !mem_we_n) store[mem_addr[7:0]] <= mem_dq_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] b, input logic [3:0] acs, cos, acc, coh, cah, acp,
                           input logic wide, input logic page);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_bank = b;
        cfg_data = {page, wide, acp, cah, coh, acc, cos, acs};
        sh_cfg[b] = cfg_data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access with per-phase cycle counting at the pins
    task automatic run_access(input string req, input logic [1:0] b, input logic wr,
                              input logic [7:0] off, input logic [63:0] wd, input bit poke);
        int a, c, x, p, h, k, beats, strobe_len, step;
        int n [5];
        int ph, i_done, n_oe, n_bad_cs, n_ready, n_wrong_strobe;
        logic wide, page, cs_low, strobe;
        logic [63:0] rd;
        a = int'(sh_cfg[b][3:0]);   c = int'(sh_cfg[b][7:4]);
        x = int'(sh_cfg[b][11:8]);  h = int'(sh_cfg[b][15:12]);
        k = int'(sh_cfg[b][19:16]); p = int'(sh_cfg[b][23:20]);
        wide = sh_cfg[b][24]; page = sh_cfg[b][25];
        if (x == 0) x = 1;
        if (p == 0) p = 1;
        beats = page ? 4 : 1;
        step  = wide ? 2 : 1;
        strobe_len = x + (page ? 3 * p : 0);
        for (int j = 0; j < 5; j++) n[j] = 0;
        ph = 0; i_done = -1; n_oe = 0; n_bad_cs = 0; n_ready = 0; n_wrong_strobe = 0; rd = '0;
        for (int j = 0; j < 256; j++) store[j] = 16'h0;

        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {b, 16'h0000, off};
        req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            req_addr  = {b + 2'd1, 16'h0000, off + 8'h40};
            req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 1; i < 400; i++) begin
            if (req_ready) n_ready++;
            if (rsp_done) begin
                i_done = i;
                rd = rsp_rdata;
                req_valid = 1'b0;
                break;
            end
            cs_low = (mem_cs_n != 4'hF);
            strobe = wr ? !mem_we_n : !mem_oe_n;
            if (wr ? !mem_oe_n : !mem_we_n) n_wrong_strobe++;
            if (cs_low && mem_cs_n != ~(4'b0001 << b)) n_bad_cs++;
            if (mem_dq_oe) n_oe++;
            if (ph == 0 && cs_low) ph = 1;
            if (ph == 1 && strobe) ph = 2;
            if (ph == 2 && !strobe) ph = 3;
            if (ph == 3 && !cs_low) ph = 4;
            n[ph]++;
            @(negedge clk);
        end
        chk(n[0] == a, "R3", "address setup cycles", 64'(n[0]), 64'(a));
        chk(n[1] == c, "R3", "cs setup cycles", 64'(n[1]), 64'(c));
        chk(n[2] == strobe_len, page ? "R8" : "R4", "strobe cycles", 64'(n[2]), 64'(strobe_len));
        chk(n[3] == h, "R3", "cs hold cycles", 64'(n[3]), 64'(h));
        chk(n[4] == k, "R3", "address hold cycles", 64'(n[4]), 64'(k));
        chk(i_done == a + c + strobe_len + h + k + 1, "R4", "done cycle index",
            64'(i_done), 64'(a + c + strobe_len + h + k + 1));
        chk(n_bad_cs == 0, "R2", "cycles with wrong chip select", 64'(n_bad_cs), 64'd0);
        chk(n_wrong_strobe == 0, "R6", "cycles with the other strobe low", 64'(n_wrong_strobe), 64'd0);
        chk(n_ready == 0, "R9", "ready cycles while busy", 64'(n_ready), 64'd0);
        if (wr) begin
            chk(n_oe == c + strobe_len + h + k, "R6", "data drive cycles",
                64'(n_oe), 64'(c + strobe_len + h + k));
            for (int j = 0; j < beats; j++) begin
                logic [15:0] e;
                e = wd[16*j +: 16];
                if (!wide) e = {8'h00, e[7:0]};
                chk(store[8'(off + j * step)] == e, page ? "R8" : "R6", "written word",
                    64'(store[8'(off + j * step)]), 64'(e));
            end
        end else begin
            logic [63:0] exp;
            exp = '0;
            chk(n_oe == 0, "R11", "data drive cycles in read", 64'(n_oe), 64'd0);
            for (int j = 0; j < beats; j++) begin
                logic [15:0] e;
                e = pat(8'(off + j * step));
                if (!wide) e = {8'h00, e[7:0]};
                exp[16*j +: 16] = e;
            end
            chk(rd == exp, wide ? "R5" : "R7", "read data", rd, exp);
        end
        @(negedge clk);
        chk(req_ready && !rsp_done && mem_cs_n == 4'hF, "R9", "idle after done (ready,done,cs)",
            {req_ready, rsp_done, mem_cs_n}, {1'b1, 1'b0, 4'hF});
    endtask

    task automatic test_reset();
        chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R1", "bus idle after reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 6'h3F);
        chk(!mem_dq_oe && !rsp_done && req_ready, "R1", "oe,done,ready after reset",
            {mem_dq_oe, rsp_done, req_ready}, 3'b001);
    endtask

    initial begin
        for (int j = 0; j < 4; j++) sh_cfg[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R10: default bank 0, shortest access; R4 with all fields zero
        run_access("R10", 2'd0, 1'b0, 8'h12, 64'h0, 1'b0);
        // R3 R5: wide bank 1 with every phase present
        set_cfg(2'd1, 4'd2, 4'd1, 4'd3, 4'd2, 4'd1, 4'd0, 1'b1, 1'b0);
        run_access("R3", 2'd1, 1'b0, 8'h20, 64'h0, 1'b0);
        // R6: write on the same bank
        run_access("R6", 2'd1, 1'b1, 8'h30, 64'h0000_0000_0000_BEEF, 1'b0);
        // R8 R7 R4: narrow page read, acc zero
        set_cfg(2'd2, 4'd1, 4'd0, 4'd0, 4'd1, 4'd0, 4'd2, 1'b0, 1'b1);
        run_access("R8", 2'd2, 1'b0, 8'h50, 64'h0, 1'b0);
        // R8: wide page write, acp zero
        set_cfg(2'd3, 4'd0, 4'd2, 4'd2, 4'd0, 4'd2, 4'd0, 1'b1, 1'b1);
        run_access("R8", 2'd3, 1'b1, 8'h60, 64'h4444_3333_2222_1111, 1'b0);
        // R9: request held during a busy access is ignored
        run_access("R9", 2'd1, 1'b0, 8'h70, 64'h0, 1'b1);
        // R10: bank 0 still at defaults after other banks were written
        run_access("R10", 2'd0, 1'b1, 8'h80, 64'h0000_0000_0000_A1B2, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule